// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked run of 8-byte region descriptors kept in a small local descriptor store. For each descriptor it hands one transfer request to a downstream data mover. Each request carries an address, a byte count, a direction and a transfer kind. The walk begins at a given descriptor index and continues through consecutive indices, wrapping at the end of the store. It stops after the first descriptor whose end flag is set.

While it walks, the block adds up the byte counts of the descriptors. When the chain finishes, it compares this sum with an expected command length. It then raises an underflow flag or an overflow flag, or neither. Any descriptor in the chain can carry a drain mark, which allows the transfer to run past the expected length without an overflow being reported. A descriptor with an unsafe length or placement stops the walk at once with a descriptor error, and no request is issued for it. Such lengths include zero (the encoding for a full 64 KiB) and anything above 65024. An unsafe placement is one that crosses a 16 MiB window.

Software or a loader fills the store through a write port, then pulses start with a start index and the expected length. The end of the walk is marked by a one-cycle done pulse. The flags stay valid until the next start.

Top module: `sgw_chain_walker`

## Requirements
- R1: A descriptor word holds the address in bits 31:0, the byte count in bits 47:32 and the flags byte in bits 63:56; bits 55:48 are unused. Each issued request carries the address and byte count of its descriptor unchanged.
- R2: Each request decodes its flags byte as follows: bit 5 drives req_write, bit 4 drives req_dma, bit 6 drives req_io and bit 2 drives req_cmdpkt.
- R3: The walk reads descriptors from start_idx at consecutive indices, wrapping modulo the store depth. It issues exactly one request per valid descriptor and stops after the descriptor whose flags bit 7 is set.
- R4: Only one request is outstanding at a time. req_valid and every request field stay stable until req_ready is seen high, and the next descriptor is read only after that acceptance.
- R5: A byte count of zero aborts the walk and sets bad_desc, with no request issued for that descriptor. A walk ending in bad_desc reports neither underflow nor overflow.
- R6: A byte count above 65024 aborts the walk with bad_desc. A count of exactly 65024 is issued.
- R7: A segment whose address bits 23:0 plus its byte count exceed 2^24 aborts the walk with bad_desc. A segment ending exactly on the 16 MiB boundary is issued, and address bits 31:24 take no part in the test.
- R8: If the byte counts of a completed walk sum to less than exp_len, underflow is set.
- R9: If the sum exceeds exp_len, overflow is set, unless any descriptor of that walk has flags bit 1 (drain) set, in which case overflow stays clear.
- R10: done is high for exactly one cycle per walk. When the sum equals exp_len both underflow and overflow are clear. The flags hold their values until the next start.
- R11: After reset the block is idle: busy, req_valid, done, underflow, overflow and bad_desc are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write strobe for the descriptor store |
| ld_idx | input | IDX_W | Store index to write |
| ld_word | input | 64 | Descriptor word to write |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_idx | input | IDX_W | Index of the first descriptor |
| exp_len | input | LEN_W | Expected total byte count |
| busy | output | 1 | A walk is in progress |
| req_valid | output | 1 | Transfer request present |
| req_ready | input | 1 | Data mover accepts the request |
| req_addr | output | 32 | Segment address |
| req_len | output | 16 | Segment byte count |
| req_write | output | 1 | Write direction |
| req_dma | output | 1 | DMA-style transfer |
| req_io | output | 1 | I/O target instead of memory |
| req_cmdpkt | output | 1 | Segment carries a command packet |
| done | output | 1 | One-cycle end-of-walk pulse |
| underflow | output | 1 | Sum fell short of exp_len |
| overflow | output | 1 | Sum exceeded exp_len without drain |
| bad_desc | output | 1 | Walk aborted on an unsafe descriptor |

## Verification
A sweep over all 32 combinations of the five decoded flag bits runs single-descriptor walks. Each expected length is set equal to, one above or one below the byte count, which separates the flag-to-pin mapping from the three length verdicts. The accept handshake is delayed by 0 to 2 cycles. Multi-descriptor chains check the order of the walk, wrap-around of the index and stopping at the end mark, with a non-end descriptor placed just past the end. The drain case shows that the drain mark hides overflow. The length limits 65024 and 65025 and the zero count fall on either side of the length rule, and segments ending on, or one byte past, the 16 MiB line fall on either side of the window rule.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  // flag bit positions inside the descriptor flags byte
  localparam int FB_DRAIN = 1;
  localparam int FB_CMD   = 2;
  localparam int FB_DMA   = 4;
  localparam int FB_WR    = 5;
  localparam int FB_IO    = 6;
  localparam int FB_END   = 7;

  typedef struct packed {
    logic [7:0]  flags;
    logic [7:0]  spare;
    logic [15:0] len;
    logic [31:0] addr;
  } sgw_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EVAL, ST_ISSUE, ST_FIN
  } sgw_state_e;
endpackage

// File: rtl/sgw_desc_ram.sv
module sgw_desc_ram #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [63:0]      wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [63:0]      rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int SEG_MAX  = 65024,
  parameter int WIN_BITS = 24
) (
  input  logic [63:0] word,
  output logic [31:0] addr,
  output logic [15:0] len,
  output logic        wr,
  output logic        dma,
  output logic        io,
  output logic        cmd,
  output logic        drain,
  output logic        last,
  output logic        bad
);
  localparam int SUM_W = WIN_BITS + 1;
  localparam logic [SUM_W-1:0] WIN_LIMIT = SUM_W'(1) << WIN_BITS;

  sgw_desc_t d;
  logic [SUM_W-1:0] span;
  logic zero_len, too_long, crosses;

  always_comb begin
    d        = sgw_desc_t'(word);
    addr     = d.addr;
    len      = d.len;
    wr       = d.flags[FB_WR];
    dma      = d.flags[FB_DMA];
    io       = d.flags[FB_IO];
    cmd      = d.flags[FB_CMD];
    drain    = d.flags[FB_DRAIN];
    last     = d.flags[FB_END];
    span     = {1'b0, d.addr[WIN_BITS-1:0]} + SUM_W'(d.len);
    zero_len = (d.len == 16'd0);
    too_long = (32'(d.len) > 32'(SEG_MAX));
    crosses  = (span > WIN_LIMIT);
    bad      = zero_len | too_long | crosses;
  end
endmodule

// File: rtl/sgw_len_tally.sv
module sgw_len_tally #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [15:0]      seg_len,
  input  logic [LEN_W-1:0] expect_len,
  output logic             short_sum,
  output logic             long_sum
);
  localparam int TOT_W = LEN_W + 1;

  logic [TOT_W-1:0] total;

  always_ff @(posedge clk) begin
    if (rst || clr) total <= '0;
    else if (add)   total <= total + TOT_W'(seg_len);
  end

  assign short_sum = total < TOT_W'(expect_len);
  assign long_sum  = total > TOT_W'(expect_len);
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int LEN_W    = 32,
  parameter int SEG_MAX  = 65024,
  parameter int WIN_BITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [63:0]      ld_word,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [LEN_W-1:0] exp_len,
  output logic             busy,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_addr,
  output logic [15:0]      req_len,
  output logic             req_write,
  output logic             req_dma,
  output logic             req_io,
  output logic             req_cmdpkt,
  output logic             done,
  output logic             underflow,
  output logic             overflow,
  output logic             bad_desc
);
  sgw_state_e       state;
  logic [IDX_W-1:0] ptr;
  logic [LEN_W-1:0] exp_q;
  logic             drain_seen, last_q;
  logic [63:0]      rd_word;

  logic [31:0] d_addr;
  logic [15:0] d_len;
  logic d_wr, d_dma, d_io, d_cmd, d_drain, d_last, d_bad;
  logic sum_short, sum_long;
  logic take_start, add_seg;

  assign take_start = (state == ST_IDLE) && start;
  assign add_seg    = (state == ST_EVAL) && !d_bad;
  assign busy       = (state != ST_IDLE);

  sgw_desc_ram #(.IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_idx),
    .wdata (ld_word),
    .raddr (ptr),
    .rdata (rd_word)
  );

  sgw_desc_decode #(.SEG_MAX(SEG_MAX), .WIN_BITS(WIN_BITS)) u_dec (
    .word  (rd_word),
    .addr  (d_addr),
    .len   (d_len),
    .wr    (d_wr),
    .dma   (d_dma),
    .io    (d_io),
    .cmd   (d_cmd),
    .drain (d_drain),
    .last  (d_last),
    .bad   (d_bad)
  );

  sgw_len_tally #(.LEN_W(LEN_W)) u_tally (
    .clk        (clk),
    .rst        (rst),
    .clr        (take_start),
    .add        (add_seg),
    .seg_len    (d_len),
    .expect_len (exp_q),
    .short_sum  (sum_short),
    .long_sum   (sum_long)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      exp_q      <= '0;
      drain_seen <= 1'b0;
      last_q     <= 1'b0;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_len    <= '0;
      req_write  <= 1'b0;
      req_dma    <= 1'b0;
      req_io     <= 1'b0;
      req_cmdpkt <= 1'b0;
      done       <= 1'b0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
      bad_desc   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ptr        <= start_idx;
            exp_q      <= exp_len;
            drain_seen <= 1'b0;
            underflow  <= 1'b0;
            overflow   <= 1'b0;
            bad_desc   <= 1'b0;
            state      <= ST_READ;
          end
        end
        ST_READ: state <= ST_EVAL;
        ST_EVAL: begin
          if (d_bad) begin
            bad_desc <= 1'b1;
            state    <= ST_FIN;
          end else begin
            req_valid  <= 1'b1;
            req_addr   <= d_addr;
            req_len    <= d_len;
            req_write  <= d_wr;
            req_dma    <= d_dma;
            req_io     <= d_io;
            req_cmdpkt <= d_cmd;
            drain_seen <= drain_seen | d_drain;
            last_q     <= d_last;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            if (last_q) state <= ST_FIN;
            else begin
              ptr   <= ptr + 1'b1;
              state <= ST_READ;
            end
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          if (!bad_desc) begin
            underflow <= sum_short;
            overflow  <= sum_long & ~drain_seen;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_chain_walker_chk.sv
module sgw_chain_walker_chk #(
  parameter int SEG_MAX  = 65024,
  parameter int WIN_BITS = 24
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [15:0] req_len,
  input logic        req_write,
  input logic        req_dma,
  input logic        req_io,
  input logic        req_cmdpkt,
  input logic        done,
  input logic        underflow,
  input logic        overflow,
  input logic        bad_desc
);
  localparam int SUM_W = WIN_BITS + 1;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
      && $stable(req_write) && $stable(req_dma) && $stable(req_io) && $stable(req_cmdpkt));

  p_nonzero_len_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_len != 16'd0);

  p_bad_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    done && bad_desc |-> !underflow && !overflow);

  p_len_cap_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> 32'(req_len) <= 32'(SEG_MAX));

  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ({1'b0, req_addr[WIN_BITS-1:0]} + SUM_W'(req_len)) <= (SUM_W'(1) << WIN_BITS));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !(underflow && overflow));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
endmodule

bind sgw_chain_walker sgw_chain_walker_chk #(.SEG_MAX(SEG_MAX), .WIN_BITS(WIN_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_write  (req_write),
  .req_dma    (req_dma),
  .req_io     (req_io),
  .req_cmdpkt (req_cmdpkt),
  .done       (done),
  .underflow  (underflow),
  .overflow   (overflow),
  .bad_desc   (bad_desc)
);

// File: tb/sgw_chain_walker_test.sv
module sgw_chain_walker_test;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;
  localparam int LEN_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [63:0] ld_word = '0;
  logic start = 1'b0;
  logic [IDX_W-1:0] start_idx = '0;
  logic [LEN_W-1:0] exp_len = '0;
  logic req_ready = 1'b0;
  logic busy, req_valid, req_write, req_dma, req_io, req_cmdpkt;
  logic done, underflow, overflow, bad_desc;
  logic [31:0] req_addr;
  logic [15:0] req_len;

  logic [63:0] shadow [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sgw_chain_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .start(start), .start_idx(start_idx), .exp_len(exp_len), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_dma(req_dma), .req_io(req_io),
    .req_cmdpkt(req_cmdpkt), .done(done), .underflow(underflow),
    .overflow(overflow), .bad_desc(bad_desc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic load(input int i, input logic [31:0] a, input logic [15:0] l,
                      input logic [7:0] f);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IDX_W'(i); ld_word = {f, 8'h00, l, a};
    shadow[i] = {f, 8'h00, l, a};
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // bench model of one walk, then drive and compare
  task automatic run_chain(input int s, input longint expl, input int hold,
                           input string bad_tag);
    logic [31:0] ea [64];
    logic [15:0] el [64];
    logic [7:0]  ef [64];
    int n = 0;
    bit ebad = 0;
    bit dr = 0;
    longint tot = 0;
    int i = s;
    int wait_n;
    bit seen_done;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] a;
      logic [15:0] l;
      logic [7:0] f;
      longint span;
      a = shadow[i][31:0];
      l = shadow[i][47:32];
      f = shadow[i][63:56];
      span = longint'(a[23:0]) + longint'(l);
      if (l == 16'd0 || l > 16'd65024 || span > 64'h100_0000) begin
        ebad = 1;
        break;
      end
      ea[n] = a; el[n] = l; ef[n] = f; n++;
      tot += longint'(l);
      dr |= f[1];
      if (f[7]) break;
      i = (i + 1) % DEPTH;
    end

    @(negedge clk);
    start = 1'b1; start_idx = IDX_W'(s); exp_len = LEN_W'(expl);
    @(negedge clk);
    start = 1'b0;
    seen_done = 0;
    for (int k = 0; k < n; k++) begin
      wait_n = 0;
      while (!req_valid && !done && wait_n < 200) begin
        @(negedge clk);
        wait_n++;
      end
      if (!req_valid) begin
        chk(0, "R3", "request missing", k, n);
        seen_done = done;
        break;
      end
      chk(req_addr == ea[k], "R1", "req_addr", req_addr, ea[k]);
      chk(req_len == el[k], "R1", "req_len", req_len, el[k]);
      chk({req_io, req_write, req_dma, req_cmdpkt} ==
          {ef[k][6], ef[k][5], ef[k][4], ef[k][2]}, "R2", "io/wr/dma/cmd",
          {req_io, req_write, req_dma, req_cmdpkt},
          {ef[k][6], ef[k][5], ef[k][4], ef[k][2]});
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(req_valid && req_addr == ea[k] && req_len == el[k], "R4",
            "request held while not accepted", {req_valid, req_addr}, {1'b1, ea[k]});
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk(!req_valid, "R4", "no new request right after accept", req_valid, 0);
    end
    if (!seen_done) begin
      wait_n = 0;
      while (!done && wait_n < 200) begin
        if (req_valid) begin
          chk(0, "R3", "request past chain end", req_addr, 0);
          req_ready = 1'b1;
          @(negedge clk);
          req_ready = 1'b0;
        end else begin
          @(negedge clk);
        end
        wait_n++;
      end
    end
    chk(done, "R10", "done pulse", done, 1);
    chk(bad_desc == ebad, bad_tag, "bad_desc", bad_desc, ebad);
    chk(underflow == (!ebad && tot < expl), "R8", "underflow", underflow,
        (!ebad && tot < expl));
    chk(overflow == (!ebad && tot > expl && !dr), "R9", "overflow", overflow,
        (!ebad && tot > expl && !dr));
    @(negedge clk);
    chk(!done, "R10", "done lasts one cycle", done, 0);
    chk(bad_desc == ebad && underflow == (!ebad && tot < expl), "R10",
        "flags held after done", {bad_desc, underflow}, {ebad, (!ebad && tot < expl)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({busy, req_valid, done, underflow, overflow, bad_desc} == 6'b0, "R11",
        "idle after reset", {busy, req_valid, done, underflow, overflow, bad_desc}, 0);

    // sweep every combination of the decoded flag bits, three length verdicts
    for (int m = 0; m < 32; m++) begin
      logic [7:0] f;
      logic [15:0] l;
      longint e;
      f = {1'b1, m[4], m[3], m[2], 1'b0, m[1], m[0], 1'b0};
      l = 16'(512 + m);
      e = (m % 3 == 0) ? longint'(l) : (m % 3 == 1) ? longint'(l) + 1 : longint'(l) - 1;
      load(m % DEPTH, 32'h0000_1004 + 32'(m) * 32'h1000, l, f);
      run_chain(m % DEPTH, e, m % 3, "R5");
    end

    // R3 three-descriptor chain; the descriptor after the end must not be taken
    load(5, 32'h0010_0000, 16'd100, 8'h10);
    load(6, 32'h0020_0000, 16'd200, 8'h20);
    load(7, 32'h0030_0000, 16'd300, 8'h80);
    load(8, 32'h0040_0000, 16'd400, 8'h00);
    run_chain(5, 600, 1, "R3");
    run_chain(5, 700, 0, "R3");

    // R3 index wrap from the last slot back to zero
    load(15, 32'h0050_0000, 16'd64, 8'h00);
    load(0, 32'h0060_0000, 16'd64, 8'h80);
    run_chain(15, 128, 0, "R3");

    // R9 drain mark hides overflow; underflow still reported
    load(2, 32'h0070_0000, 16'd256, 8'h00);
    load(3, 32'h0080_0000, 16'd256, 8'h02);
    load(4, 32'h0090_0000, 16'd256, 8'h80);
    run_chain(2, 500, 0, "R9");
    run_chain(2, 900, 0, "R9");

    // R5 zero count on the second descriptor
    load(9, 32'h0000_2000, 16'd128, 8'h00);
    load(10, 32'h0000_3000, 16'd0, 8'h80);
    run_chain(9, 128, 0, "R5");

    // R6 length cap on either side
    load(11, 32'h0000_0000, 16'd65024, 8'h80);
    run_chain(11, 65024, 0, "R6");
    load(11, 32'h0000_0000, 16'd65025, 8'h80);
    run_chain(11, 65025, 0, "R6");

    // R7 16 MiB window: exact end, one past, high address bits ignored
    load(12, 32'h00FF_FF00, 16'h0100, 8'h80);
    run_chain(12, 256, 0, "R7");
    load(12, 32'h00FF_FF01, 16'h0100, 8'h80);
    run_chain(12, 256, 0, "R7");
    load(12, 32'h7AFF_FF00, 16'h0100, 8'h80);
    run_chain(12, 256, 0, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule